// File: doc/BRIEF.md
# Cascaded State-Variable Lowpass Filter

This block is an eight-pole digital lowpass filter for a stream of signed 16-bit samples. It is built as four second-order sections in series. Each section is a digital model of an analog state-variable filter: two integrators, one for the band-pass state and one for the low-pass state. Each section has exactly unity gain at DC, and the low-pass state of one section feeds the next. A single 18x18 signed multiplier and a 48-bit adder are shared by all sections. Each sample takes twelve multiply steps, and results are rounded and saturated to 16 bits.

The frequency coefficient of each section is an 18-bit mantissa plus a coarse right shift. This lets cutoffs far below the sample rate keep a usable mantissa, down to a cutoff-to-sample ratio near one in a million. Software writes the mantissa, shift and damping coefficient of a section in one write cycle. Computing the coefficients is done elsewhere.

Top module: `svf_lp8`

## Requirements
- R1: While reset is active and after it is released, `in_ready` is 1, `out_valid` is 0 and `out_sample` is 0.
- R2: A sample is taken only on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until processing ends, and `in_valid` asserted while `in_ready` is 0 is ignored.
- R3: `out_valid` is high for exactly one cycle: the cycle that follows the 12th rising edge after the accepting edge (three steps per section). `in_ready` is 1 in that same cycle.
- R4: State values are signal times 2^24, held in 48 bits. The operand reduction op(v) is floor(v/2^23), clamped to the 18-bit signed range. The product term(v,c,r) is floor(op(v)*c*2^7 / 2^r). Per section, in this order:
  - t = x − lp − term(bp, d, 0)
  - bp = bp + term(t, f, s+1)
  - lp = lp + term(bp, f, s+1), using the new bp.
- R5: Section 0 takes x = sample·2^24; each later section takes the just-updated lp of the section before it. `out_sample` = floor((lp3 + 2^23)/2^24), saturated to [−32768, 32767].
- R6: Every state, and the intermediate t, saturates at −2^47 and 2^47−1 instead of wrapping.
- R7: With a constant input and stable coefficients, the output settles to within 2 LSB of the input (unity DC gain).
- R8: A cycle with `cfg_we`=1 writes all three coefficients of section `cfg_sec`:
  - `cfg_freq` is f, signed, weight 2^-17 before the extra shift.
  - `cfg_damp` is d, signed, weight 2^-16.
  - `cfg_shift` is s, 0..31.
  A zero f gives zero output, and a large s makes a section correspondingly slower.
- R9: Reset clears all integrator states, all coefficients and the step sequencer, including when it arrives in the middle of a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_sample | input | 16 | Signed input sample |
| in_ready | output | 1 | Filter idle, can take a sample |
| out_valid | output | 1 | One-cycle pulse per processed sample |
| out_sample | output | 16 | Signed filtered sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sec | input | 2 | Section selected for the write |
| cfg_freq | input | 18 | Frequency mantissa, signed |
| cfg_damp | input | 18 | Damping coefficient, signed |
| cfg_shift | input | 5 | Extra right shift of frequency products |

## Verification
The bench builds the filter with the default four sections, so the complete cascade and the twelve-step latency are exercised. Different coefficient sets then bring distinct regions of behaviour within reach:
- Mid-range mantissas with small shifts make the DC settling reachable within a few hundred samples.
- A shift of 20 shows the coarse scaling holding a section silent.
- Negative damping drives the integrators into their saturation bounds within tens of samples.

A bit-exact reference of the section arithmetic is used to compare every output.

// File: rtl/svf_pkg.sv
package svf_pkg;
  localparam int SMP_W    = 16;              // sample width
  localparam int ACC_W    = 48;              // integrator / accumulator width
  localparam int OPD_W    = 18;              // multiplier operand width
  localparam int SHF_W    = 5;               // coarse shift field width
  localparam int FRAC     = 24;              // weight of one sample LSB in state
  localparam int OP_DROP  = FRAC - 1;        // bits dropped when forming an operand
  localparam int DMP_FRAC = 16;              // fraction bits of the damping coefficient
  localparam int PRE_LSH  = OP_DROP - DMP_FRAC;

  typedef logic signed [ACC_W-1:0]   acc_t;
  typedef logic signed [ACC_W+1:0]   wide_t;
  typedef logic signed [OPD_W-1:0]   opd_t;
  typedef logic signed [2*OPD_W-1:0] prod_t;
  typedef enum logic [1:0] {PH_DAMP, PH_BAND, PH_LOW} phase_e;

  function automatic wide_t widen(input acc_t v);
    return wide_t'(v);
  endfunction

  // clamp a wide sum into the state range
  function automatic acc_t sat_wide(input wide_t v);
    wide_t hi, lo;
    hi = '0; hi[ACC_W-2:0] = '1;
    lo = '1; lo[ACC_W-2:0] = '0;
    if (v > hi) return hi[ACC_W-1:0];
    if (v < lo) return lo[ACC_W-1:0];
    return v[ACC_W-1:0];
  endfunction

  // reduce a state value to a multiplier operand
  function automatic opd_t to_opd(input acc_t v);
    acc_t q, hi, lo;
    q  = v >>> OP_DROP;
    hi = '0; hi[OPD_W-2:0] = '1;
    lo = '1; lo[OPD_W-2:0] = '0;
    if (q > hi) return hi[OPD_W-1:0];
    if (q < lo) return lo[OPD_W-1:0];
    return q[OPD_W-1:0];
  endfunction

  // product scaled back into state units, then coarse right shift
  function automatic acc_t scale_term(input opd_t a, input opd_t c,
                                      input logic [SHF_W:0] rs);
    prod_t p;
    acc_t  w;
    p = a * c;
    w = acc_t'(p) <<< PRE_LSH;
    return w >>> rs;
  endfunction

  // round half up and saturate to the sample range
  function automatic logic signed [SMP_W-1:0] round_out(input acc_t v);
    wide_t r, hi, lo;
    r  = widen(v) + (wide_t'(1) <<< (FRAC - 1));
    r  = r >>> FRAC;
    hi = '0; hi[SMP_W-2:0] = '1;
    lo = '1; lo[SMP_W-2:0] = '0;
    if (r > hi) return hi[SMP_W-1:0];
    if (r < lo) return lo[SMP_W-1:0];
    return r[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/svf_coef_bank.sv
module svf_coef_bank
  import svf_pkg::*;
#(
  parameter int N_SEC = 4,
  localparam int SEC_W = $clog2(N_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEC_W-1:0] wsec,
  input  opd_t             wfreq,
  input  opd_t             wdamp,
  input  logic [SHF_W-1:0] wshift,
  input  logic [SEC_W-1:0] rsec,
  output opd_t             freq,
  output opd_t             damp,
  output logic [SHF_W-1:0] shift
);
  opd_t             f_all [N_SEC];
  opd_t             d_all [N_SEC];
  logic [SHF_W-1:0] s_all [N_SEC];

  for (genvar k = 0; k < N_SEC; k++) begin : g_sec
    opd_t             f_r, d_r;
    logic [SHF_W-1:0] s_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        f_r <= '0;
        d_r <= '0;
        s_r <= '0;
      end else if (we && wsec == SEC_W'(k)) begin
        f_r <= wfreq;
        d_r <= wdamp;
        s_r <= wshift;
      end
    end
    assign f_all[k] = f_r;
    assign d_all[k] = d_r;
    assign s_all[k] = s_r;
  end

  assign freq  = f_all[rsec];
  assign damp  = d_all[rsec];
  assign shift = s_all[rsec];
endmodule

// File: rtl/svf_ctrl.sv
module svf_ctrl
  import svf_pkg::*;
#(
  parameter int N_SEC = 4,
  localparam int SEC_W = $clog2(N_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             accept,
  output logic             busy,
  output logic [SEC_W-1:0] sec,
  output phase_e           phase,
  output logic             last_step
);
  logic             busy_q;
  logic [SEC_W-1:0] sec_q;
  phase_e           ph_q;

  assign in_ready  = !busy_q;
  assign accept    = in_valid && !busy_q;
  assign last_step = busy_q && ph_q == PH_LOW && sec_q == SEC_W'(N_SEC - 1);
  assign busy      = busy_q;
  assign sec       = sec_q;
  assign phase     = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sec_q  <= '0;
      ph_q   <= PH_DAMP;
    end else if (accept) begin
      busy_q <= 1'b1;
      sec_q  <= '0;
      ph_q   <= PH_DAMP;
    end else if (busy_q) begin
      case (ph_q)
        PH_DAMP: ph_q <= PH_BAND;
        PH_BAND: ph_q <= PH_LOW;
        default: begin
          ph_q <= PH_DAMP;
          if (last_step) busy_q <= 1'b0;
          else           sec_q  <= sec_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/svf_mul_shift.sv
module svf_mul_shift
  import svf_pkg::*;
(
  input  acc_t             src,
  input  opd_t             coef,
  input  logic [SHF_W:0]   rshift,
  output acc_t             term
);
  opd_t opd;
  assign opd  = to_opd(src);
  assign term = scale_term(opd, coef, rshift);
endmodule

// File: rtl/svf_lp8.sv
module svf_lp8
  import svf_pkg::*;
#(
  parameter int N_SEC = 4,
  localparam int SEC_W = $clog2(N_SEC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_sample,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic signed [SMP_W-1:0] out_sample,
  input  logic                    cfg_we,
  input  logic [SEC_W-1:0]        cfg_sec,
  input  logic signed [OPD_W-1:0] cfg_freq,
  input  logic signed [OPD_W-1:0] cfg_damp,
  input  logic [SHF_W-1:0]        cfg_shift
);
  logic             accept, busy, last_step;
  logic [SEC_W-1:0] sec;
  phase_e           phase;

  svf_ctrl #(.N_SEC(N_SEC)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .busy(busy), .sec(sec), .phase(phase),
    .last_step(last_step)
  );

  opd_t             c_freq, c_damp;
  logic [SHF_W-1:0] c_shift;

  svf_coef_bank #(.N_SEC(N_SEC)) u_coef (
    .clk(clk), .rst(rst), .we(cfg_we), .wsec(cfg_sec),
    .wfreq(cfg_freq), .wdamp(cfg_damp), .wshift(cfg_shift),
    .rsec(sec), .freq(c_freq), .damp(c_damp), .shift(c_shift)
  );

  // integrator states and step registers
  acc_t lp_q [N_SEC];
  acc_t bp_q [N_SEC];
  acc_t tmp_q, x_q;
  acc_t lp_cur, bp_cur;
  assign lp_cur = lp_q[sec];
  assign bp_cur = bp_q[sec];

  // operand selection for the shared multiplier
  acc_t           mul_src;
  opd_t           mul_coef;
  logic [SHF_W:0] mul_rs, f_rs;
  assign f_rs = {1'b0, c_shift} + 1'b1;

  always_comb begin
    case (phase)
      PH_DAMP: begin mul_src = bp_cur; mul_coef = c_damp; mul_rs = '0;   end
      PH_BAND: begin mul_src = tmp_q;  mul_coef = c_freq; mul_rs = f_rs; end
      default: begin mul_src = bp_cur; mul_coef = c_freq; mul_rs = f_rs; end
    endcase
  end

  acc_t term;
  svf_mul_shift u_mul (.src(mul_src), .coef(mul_coef), .rshift(mul_rs), .term(term));

  // accumulator: difference step and integration step
  acc_t diff_sat, integ_sat, integ_base;
  assign diff_sat   = sat_wide(widen(x_q) - widen(lp_cur) - widen(term));
  assign integ_base = (phase == PH_BAND) ? bp_cur : lp_cur;
  assign integ_sat  = sat_wide(widen(integ_base) + widen(term));

  logic upd_tmp, upd_bp, upd_lp;
  assign upd_tmp = busy && phase == PH_DAMP;
  assign upd_bp  = busy && phase == PH_BAND;
  assign upd_lp  = busy && phase == PH_LOW;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_SEC; k++) begin
        lp_q[k] <= '0;
        bp_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < N_SEC; k++) begin
        if (upd_bp && sec == SEC_W'(k)) bp_q[k] <= integ_sat;
        if (upd_lp && sec == SEC_W'(k)) lp_q[k] <= integ_sat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_q <= '0;
      x_q   <= '0;
    end else begin
      if (accept)  x_q   <= acc_t'(in_sample) <<< FRAC;
      if (upd_tmp) tmp_q <= diff_sat;
      if (upd_lp)  x_q   <= integ_sat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= last_step;
      if (last_step) out_sample <= round_out(integ_sat);
    end
  end
endmodule

// File: rtl/svf_lp8_chk.sv
module svf_lp8_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic last_step
);
  // R3
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R3
  ready_with_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);
  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R3
  done_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    last_step |=> out_valid);
  // R2
  no_out_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !last_step) |=> !out_valid);
endmodule

bind svf_lp8 svf_lp8_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .last_step(last_step)
);

// File: tb/sim_svf_lp8.sv
`timescale 1ns/1ps
module sim_svf_lp8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_sample;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sec = '0;
  logic signed [17:0] cfg_freq = '0, cfg_damp = '0;
  logic [4:0] cfg_shift = '0;

  always #4 clk = ~clk;

  svf_lp8 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample),
    .cfg_we(cfg_we), .cfg_sec(cfg_sec), .cfg_freq(cfg_freq),
    .cfg_damp(cfg_damp), .cfg_shift(cfg_shift)
  );

  int checks = 0;
  int errors = 0;

  // reference model, restated from the requirement formulas
  longint m_lp [4];
  longint m_bp [4];
  longint m_f [4];
  longint m_d [4];
  longint m_s [4];

  localparam longint ST_MAX = (64'sd1 <<< 47) - 1;
  localparam longint ST_MIN = -(64'sd1 <<< 47);

  function automatic longint clampl(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint m_term(longint v, longint c, longint r);
    longint op;
    op = clampl(v >>> 23, -131072, 131071);
    return (op * c * 128) >>> r;
  endfunction

  function automatic int m_step(int smp);
    longint x, t;
    for (int k = 0; k < 4; k++) begin
      x = (k == 0) ? (longint'(smp) * 64'sd16777216) : m_lp[k-1];
      t = clampl(x - m_lp[k] - m_term(m_bp[k], m_d[k], 0), ST_MIN, ST_MAX);
      m_bp[k] = clampl(m_bp[k] + m_term(t, m_f[k], m_s[k] + 1), ST_MIN, ST_MAX);
      m_lp[k] = clampl(m_lp[k] + m_term(m_bp[k], m_f[k], m_s[k] + 1), ST_MIN, ST_MAX);
    end
    return int'(clampl((m_lp[3] + 64'sd8388608) >>> 24, -32768, 32767));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      m_lp[k] = 0; m_bp[k] = 0; m_f[k] = 0; m_d[k] = 0; m_s[k] = 0;
    end
  endtask

  task automatic cfg(input int sec, input int f, input int d, input int s);
    cfg_we = 1'b1; cfg_sec = sec[1:0];
    cfg_freq = f[17:0]; cfg_damp = d[17:0]; cfg_shift = s[4:0];
    @(negedge clk);
    cfg_we = 1'b0;
    m_f[sec] = f; m_d[sec] = d; m_s[sec] = s;
  endtask

  task automatic cfg_set_a();
    cfg(0, 40000, 90000, 0);
    cfg(1, 60000, 65536, 1);
    cfg(2, 100000, 92682, 0);
    cfg(3, 80000, 70000, 2);
  endtask

  // send one sample, check latency (R3) and value against the model
  task automatic run_sample(input int smp, input string req, output int y);
    int cnt, guard, exp;
    guard = 0;
    while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
    in_valid = 1'b1; in_sample = smp[15:0];
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    while (!out_valid && cnt < 100) begin @(negedge clk); cnt++; end
    chk(cnt == 13, "R3 latency", cnt, 13);
    chk(in_ready == 1'b1, "R3 ready with output", in_ready, 1);
    y = int'(out_sample);
    exp = m_step(smp);
    chk(y == exp, req, y, exp);
  endtask

  localparam int NV = 24;
  localparam int VEC [NV] = '{0, 1000, 1000, 1000, -2000, 32767, 32767, -32768,
                              -32768, 500, 0, 0, 12345, -12345, 7, -7,
                              20000, 20000, 20000, -1, 0, 30000, -30000, 100};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int y, y0, mism, guard;
    bit saw;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(out_sample == 16'sd0, "R1 out_sample", out_sample, 0);

    // R8 zero coefficients after reset give zero output
    run_sample(20000, "R8 zero coef", y);
    chk(y == 0, "R8 zero coef output", y, 0);

    // R4 R5 table walk
    cfg_set_a();
    for (int i = 0; i < NV; i++) run_sample(VEC[i], "R4 R5 table", y);

    // R2 samples offered while busy are ignored
    guard = 0;
    while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
    in_valid = 1'b1; in_sample = 16'sd15000;
    @(negedge clk);
    in_sample = -16'sd30000;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b0, "R2 busy", in_ready, 0);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    guard = 0;
    while (!out_valid && guard < 100) begin @(negedge clk); guard++; end
    y0 = m_step(15000);
    chk(int'(out_sample) == y0, "R2 ignored during busy", out_sample, y0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 no extra output", out_valid, 0);
    run_sample(15000, "R2 next sample", y);

    // R7 DC gain
    mism = 0;
    for (int i = 0; i < 500; i++) begin
      run_sample(1000, "R7 settle", y);
    end
    chk((y - 1000) <= 2 && (1000 - y) <= 2, "R7 DC gain", y, 1000);

    // R8 coarse shift keeps a tiny-coefficient section quiet
    do_reset();
    cfg(0, 131071, 92682, 20);
    cfg(1, 120000, 92682, 0);
    cfg(2, 120000, 92682, 0);
    cfg(3, 120000, 92682, 0);
    for (int i = 0; i < 5; i++) run_sample(32767, "R8 coarse shift", y);
    chk(y == 0, "R8 tiny coefficient output", y, 0);

    // R6 saturation under negative damping
    do_reset();
    for (int k = 0; k < 4; k++) cfg(k, 131071, -65536, 0);
    saw = 1'b0;
    for (int i = 0; i < 60; i++) begin
      run_sample(32767, "R6 saturating", y);
      if (y == 32767 || y == -32768) saw = 1'b1;
    end
    chk(saw, "R6 full scale reached", saw, 1);

    // R9 reset in the middle of a sample
    cfg_set_a();
    guard = 0;
    while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
    in_valid = 1'b1; in_sample = 16'sd9000;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    do_reset();
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    saw = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid) saw = 1'b1;
    end
    chk(!saw, "R9 no stale output", saw, 0);
    run_sample(9000, "R9 coefficients cleared", y);
    chk(y == 0, "R9 zero after reset", y, 0);
    cfg_set_a();
    run_sample(9000, "R9 states cleared", y);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule